// File: doc/BRIEF.md
# Pseudo-Random Bit Sequence Checker

This block checks a serial receive stream, one bit per valid strobe, against one of four maximal-length pseudo-random sequences. It synchronises to the stream by itself. It fills its shift register from the incoming bits, then predicts each following bit from that history. Once it has seen enough consecutive correct predictions, it declares lock. From then on it free-runs on its own predictions, so each corrupted line bit is counted exactly once.

The expected sequence is picked with a one-hot select. A polarity control states whether the line carries the sequence inverted. The checker only advances when both the test enable and the clock enable are high. Results come out as three signals: a lock flag, a sticky error flag, and a saturating error count. In a loopback test, the polarity control has to match the generator's polarity setting, or the checker never locks.

Top module: `prbs_chk`

## Requirements
- R1: `poly_sel` is one-hot. Bit 0 selects x^7+x^6+1, bit 1 selects x^9+x^5+1, bit 2 selects x^23+x^18+1 and bit 3 selects x^31+x^28+1. Any value that is not one-hot holds the checker unlocked, with `done` at 0.
- R2: When `pol_plain` is 0, each received bit is inverted before comparison. When it is 1, the bit is used as received. A stream whose polarity differs from this setting never raises `done`.
- R3: The checker advances only in cycles where `test_en` and `clk_en` are both 1. With `clk_en` at 0, valid bits are ignored, the sequence position is not advanced, and `done`, `err` and `err_cnt` hold.
- R4: With an order N polynomial, the first N valid bits seed the history. `done` rises at the clock edge of the 3N-th valid bit, after 2N consecutive correct predictions. A misprediction before lock restarts seeding.
- R5: After lock, each valid bit that differs from the prediction sets the sticky `err` and raises `err_cnt` by exactly one. Prediction continues from the predicted bit, so one flipped bit costs one count.
- R6: `err_cnt` saturates at 2^CNT_W-1 and never wraps.
- R7: A `clr` pulse clears `err` and `err_cnt` at the next edge and leaves `done` unchanged.
- R8: While `test_en` is 0, `done`, `err` and `err_cnt` are 0 from the next edge on, and locking starts over afterwards.
- R9: A change of `poly_sel` in an active cycle clears `done` at that edge and restarts seeding. The bit offered in that cycle is ignored.
- R10: After reset, `done`, `err` and `err_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Receive test enable; low clears status |
| clk_en | input | 1 | Receive checker clock enable; low freezes the checker |
| poly_sel | input | 4 | One-hot expected-polynomial select |
| pol_plain | input | 1 | 0: line data expected inverted; 1: expected as is |
| clr | input | 1 | Clears error flag and count |
| din_vld | input | 1 | Strobe for `din` |
| din | input | 1 | Received bit |
| done | output | 1 | Locked to the expected sequence |
| err | output | 1 | Sticky mismatch flag after lock |
| err_cnt | output | CNT_W | Saturating mismatch count |

## Verification
The hardest situation to reach from the ports is saturation of the error count. It needs a locked checker followed by 2^CNT_W misaligned bits. The stimulus gets there with a second instance that has a 4-bit counter, fed the same locked stream and deliberately flipped bits. The full-width instance meanwhile confirms the exact tally. The bench also exercises every polynomial under both polarities. For each pair it checks the exact lock edge at bit 3N, counted bit errors, freezing under `clk_en`, and polarity mismatch that never locks.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int NUM_POLY = 4;
    localparam int HIST_W   = 31;
    localparam int PH_W     = 7;

    typedef enum logic [1:0] {
        ST_SEED = 2'd0,
        ST_SYNC = 2'd1,
        ST_LOCK = 2'd2
    } chk_st_e;

    // order of polynomial index i (degree of highest term)
    function automatic int poly_order(input int i);
        case (i)
            0:       return 7;
            1:       return 9;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    // second feedback term of polynomial index i
    function automatic int poly_tap(input int i);
        case (i)
            0:       return 6;
            1:       return 5;
            2:       return 18;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/prbs_chk_pred.sv
module prbs_chk_pred
    import prbs_chk_pkg::*;
(
    input  logic [HIST_W-1:0]   hist_i,
    input  logic [NUM_POLY-1:0] sel_i,
    output logic                pred_o,
    output logic [PH_W-1:0]     order_o,
    output logic                sel_ok_o
);

    logic [NUM_POLY-1:0]           tap_bit;
    logic [NUM_POLY-1:0][PH_W-1:0] ord;

    // hist_i[k] holds the bit received k+1 positions ago
    for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
        assign tap_bit[g] = hist_i[poly_order(g)-1] ^ hist_i[poly_tap(g)-1];
        assign ord[g]     = PH_W'(poly_order(g));
    end

    always_comb begin
        pred_o  = 1'b0;
        order_o = '0;
        for (int i = 0; i < NUM_POLY; i++) begin
            if (sel_i[i]) begin
                pred_o  = pred_o | tap_bit[i];
                order_o = order_o | ord[i];
            end
        end
    end

    assign sel_ok_o = $onehot(sel_i);

endmodule

// File: rtl/prbs_chk_errcnt.sv
module prbs_chk_errcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             err_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } ec_t;

    ec_t ec_d, ec_q;

    always_comb begin
        ec_d = ec_q;
        if (clr_i) begin
            ec_d.cnt = '0;
            ec_d.err = 1'b0;
        end else if (hit_i) begin
            ec_d.err = 1'b1;
            if (ec_q.cnt != {CNT_W{1'b1}}) begin
                ec_d.cnt = ec_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ec_q <= '0;
        end else begin
            ec_q <= ec_d;
        end
    end

    assign cnt_o = ec_q.cnt;
    assign err_o = ec_q.err;

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                test_en,
    input  logic                clk_en,
    input  logic [NUM_POLY-1:0] poly_sel,
    input  logic                pol_plain,
    input  logic                clr,
    input  logic                din_vld,
    input  logic                din,
    output logic                done,
    output logic                err,
    output logic [CNT_W-1:0]    err_cnt
);

    typedef struct packed {
        chk_st_e             st;
        logic [HIST_W-1:0]   hist;
        logic [PH_W-1:0]     ph;
        logic [NUM_POLY-1:0] sel;
        logic                done;
    } chk_t;

    chk_t r_d, r_q;

    logic            pred;
    logic [PH_W-1:0] order;
    logic            sel_ok;
    logic            rx_bit;
    logic            sel_chg;
    logic            hit;
    logic [PH_W-1:0] sync_len;

    prbs_chk_pred u_pred (
        .hist_i   (r_q.hist),
        .sel_i    (r_q.sel),
        .pred_o   (pred),
        .order_o  (order),
        .sel_ok_o (sel_ok)
    );

    assign rx_bit   = din ^ ~pol_plain;
    assign sel_chg  = (poly_sel != r_q.sel);
    assign sync_len = PH_W'({order, 1'b0});

    always_comb begin
        r_d = r_q;
        hit = 1'b0;
        if (!test_en) begin
            r_d.st   = ST_SEED;
            r_d.ph   = '0;
            r_d.done = 1'b0;
            r_d.sel  = poly_sel;
        end else if (clk_en) begin
            if (sel_chg || !sel_ok) begin
                r_d.st   = ST_SEED;
                r_d.ph   = '0;
                r_d.done = 1'b0;
                r_d.sel  = poly_sel;
            end else if (din_vld) begin
                case (r_q.st)
                    ST_SEED: begin
                        r_d.hist = {r_q.hist[HIST_W-2:0], rx_bit};
                        if (r_q.ph == order - 1'b1) begin
                            r_d.st = ST_SYNC;
                            r_d.ph = '0;
                        end else begin
                            r_d.ph = r_q.ph + 1'b1;
                        end
                    end
                    ST_SYNC: begin
                        r_d.hist = {r_q.hist[HIST_W-2:0], rx_bit};
                        if (rx_bit == pred) begin
                            if (r_q.ph == sync_len - 1'b1) begin
                                r_d.st   = ST_LOCK;
                                r_d.ph   = '0;
                                r_d.done = 1'b1;
                            end else begin
                                r_d.ph = r_q.ph + 1'b1;
                            end
                        end else begin
                            r_d.st = ST_SEED;
                            r_d.ph = '0;
                        end
                    end
                    ST_LOCK: begin
                        r_d.hist = {r_q.hist[HIST_W-2:0], pred};
                        hit      = (rx_bit != pred);
                    end
                    default: begin
                        r_d.st = ST_SEED;
                        r_d.ph = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_SEED, hist: '0, ph: '0, sel: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    prbs_chk_errcnt #(
        .CNT_W (CNT_W)
    ) u_errcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr | ~test_en),
        .hit_i (hit),
        .cnt_o (err_cnt),
        .err_o (err)
    );

    assign done = r_q.done;

endmodule

// File: rtl/prbs_chk_sva.sv
module prbs_chk_sva
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                test_en,
    input logic                clk_en,
    input logic [NUM_POLY-1:0] poly_sel,
    input logic                clr,
    input logic                din_vld,
    input logic                done,
    input logic                err,
    input logic [CNT_W-1:0]    err_cnt
);

    AST_SEL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && clk_en && !$onehot(poly_sel)) |=> !done); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !clk_en && !clr) |=> ($stable(done) && $stable(err) && $stable(err_cnt))); // R3

    AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(test_en && clk_en && din_vld)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && test_en && !clr) |=> err); // R5

    AST_CNT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != '0) |-> err); // R5

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !clr) |=> ((err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1))); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !clr) |=> (err_cnt >= $past(err_cnt))); // R6

    AST_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_cnt == '0 && !err)); // R7

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (!done && !err && err_cnt == '0)); // R8

    AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && clk_en && (poly_sel != $past(poly_sel))) |=> !done); // R9

endmodule

bind prbs_chk prbs_chk_sva #(
    .CNT_W (CNT_W)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .clk_en   (clk_en),
    .poly_sel (poly_sel),
    .clr      (clr),
    .din_vld  (din_vld),
    .done     (done),
    .err      (err),
    .err_cnt  (err_cnt)
);

// File: tb/prbs_chk_tb.sv
module prbs_chk_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_en = 1'b0;
    logic        clk_en = 1'b0;
    logic [3:0]  poly_sel = 4'b0001;
    logic        pol_plain = 1'b0;
    logic        clr = 1'b0;
    logic        din_vld = 1'b0;
    logic        din = 1'b0;
    logic        done_a, err_a, done_b, err_b;
    logic [15:0] cnt_a;
    logic [3:0]  cnt_b;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench generator state
    logic [30:0] gh;
    int          g_ord;
    int          g_tap;
    logic        tx_pol;

    always #5 clk = ~clk;

    prbs_chk #(.CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .clk_en(clk_en),
        .poly_sel(poly_sel), .pol_plain(pol_plain), .clr(clr),
        .din_vld(din_vld), .din(din),
        .done(done_a), .err(err_a), .err_cnt(cnt_a)
    );

    prbs_chk #(.CNT_W(4)) u_small (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .clk_en(clk_en),
        .poly_sel(poly_sel), .pol_plain(pol_plain), .clr(clr),
        .din_vld(din_vld), .din(din),
        .done(done_b), .err(err_b), .err_cnt(cnt_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_poly(input int s);
        case (s)
            0: begin g_ord = 7;  g_tap = 6;  end
            1: begin g_ord = 9;  g_tap = 5;  end
            2: begin g_ord = 23; g_tap = 18; end
            default: begin g_ord = 31; g_tap = 28; end
        endcase
        gh = 31'h5A5A_1F3C;
    endtask

    // all tasks start and end at a falling edge
    task automatic send(input bit flip);
        logic b;
        b  = gh[g_ord-1] ^ gh[g_tap-1];
        gh = {gh[29:0], b};
        din     = (tx_pol ? b : ~b) ^ flip;
        din_vld = 1'b1;
        @(negedge clk);
        din_vld = 1'b0;
    endtask

    task automatic send_n(input int n);
        for (int i = 0; i < n; i++) send(1'b0);
    endtask

    task automatic idle(input int n);
        din_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input int s, input bit p);
        test_en   = 1'b0;
        clk_en    = 1'b1;
        poly_sel  = 4'(1 << s);
        pol_plain = p;
        tx_pol    = p;
        set_poly(s);
        idle(1);
        test_en = 1'b1;
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R10 done", done_a, 0);
        check("R10 err", err_a, 0);
        check("R10 cnt", cnt_a, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 2; p++) begin
                int n;
                int k;
                start(s, p[0]);
                n = g_ord;
                send_n(3 * n - 1);
                check("R4 early", done_a, 0);
                send(1'b0);
                check("R4 R1 R2 lock", done_a, 1);
                check("R5 clean", err_a, 0);
                // R5 counted bit errors
                k = s + 2;
                for (int e = 0; e < k; e++) begin
                    send(1'b1);
                    send_n(e);
                end
                check("R5 count", cnt_a, k);
                check("R5 small count", cnt_b, k);
                check("R5 sticky", err_a, 1);
                check("R5 still locked", done_a, 1);
                // R7 clear pulse
                clr = 1'b1;
                idle(1);
                clr = 1'b0;
                check("R7 cnt", cnt_a, 0);
                check("R7 err", err_a, 0);
                check("R7 done kept", done_a, 1);
                // R3 frozen with clk_en low: junk ignored, position not advanced
                clk_en = 1'b0;
                for (int j = 0; j < 10; j++) begin
                    din = j[0];
                    din_vld = 1'b1;
                    @(negedge clk);
                end
                din_vld = 1'b0;
                check("R3 frozen cnt", cnt_a, 0);
                check("R3 frozen done", done_a, 1);
                clk_en = 1'b1;
                send_n(20);
                check("R3 resumed in step", cnt_a, 0);
                send(1'b1);
                check("R5 single", cnt_a, 1);
                // R8 test enable low clears everything
                test_en = 1'b0;
                idle(1);
                check("R8 done", done_a, 0);
                check("R8 err", err_a, 0);
                check("R8 cnt", cnt_a, 0);
                // R2 polarity mismatch never locks
                pol_plain = ~p[0];
                test_en = 1'b1;
                idle(1);
                send_n(6 * n);
                check("R2 mismatch", done_a, 0);
            end
        end

        // R6 saturation on the narrow counter
        start(0, 1'b1);
        send_n(21);
        check("R6 lock", done_b, 1);
        for (int e = 0; e < 20; e++) begin
            send(1'b1);
            send(1'b0);
        end
        check("R6 saturated", cnt_b, 15);
        check("R6 wide", cnt_a, 20);
        send(1'b1);
        check("R6 held", cnt_b, 15);

        // R9 polynomial change restarts lock
        start(0, 1'b0);
        send_n(21);
        check("R9 pre lock", done_a, 1);
        poly_sel = 4'b0010;
        set_poly(1);
        idle(1);
        check("R9 cleared", done_a, 0);
        send_n(26);
        check("R9 relock early", done_a, 0);
        send(1'b0);
        check("R9 relock", done_a, 1);

        // R1 non one-hot select never locks
        start(0, 1'b1);
        poly_sel = 4'b0011;
        idle(1);
        send_n(200);
        check("R1 bad sel", done_a, 0);
        poly_sel = 4'b0000;
        send_n(50);
        check("R1 zero sel", done_a, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule